// File: doc/BRIEF.md
# Fully-Associative Translation Cache with Access Permission Check

This block caches virtual-to-physical page translations for a processor pipeline. A lookup presents a 32-bit virtual address, the kind of access (read, write or instruction fetch) and the current privilege level. One cycle later the block gives one of three results. A hit returns the physical address. A miss tells the page table walker that it must fetch a translation. A protection fault means a translation exists but the access is not allowed. The low 12 address bits are the page offset and are never translated. The upper 20 bits form the page number, which is compared against every valid slot at once.

The walker loads translations through a refill port. A refill goes into the slot that already holds that page, if there is one. Otherwise it goes into the lowest empty slot, and when every slot is full it goes into a round-robin victim. Slots hold no process tag, so the operating system raises the flush input on every process switch to empty the whole cache. Each slot also keeps an accessed bit and a dirty bit. The first permitted access to a page, and the first permitted write to it, are reported on a side port so that the backing page table entry can be updated.

Top module: `fa_tlb`

## Requirements
- R1: After reset every slot is empty, all result and feedback outputs are 0, and the first lookup reports a miss.
- R2: A lookup whose page number matches a valid slot and whose access is allowed sets `rs_hit` in the next cycle, with `rs_paddr` = {slot physical page, lookup bits 11:0}.
- R3: A lookup that matches no valid slot sets `rs_miss` in the next cycle, with `rs_paddr` = 0.
- R4: Access encoding is 0 = read, 1 = write, 2 = execute, 3 = reserved. Permission encoding is bit0 read, bit1 write, bit2 execute, bit3 kernel-only. A matching access whose type bit is clear, or whose type is 3, sets `rs_fault` with `rs_paddr` = 0.
- R5: A kernel-only slot faults for a lookup with `lk_kernel` = 0. With `lk_kernel` = 1 it follows only its read, write and execute bits. Kernel mode may also use slots that are not kernel-only.
- R6: `rs_valid` is high exactly one cycle after `lk_valid`. While it is high, exactly one of hit, miss and fault is set. While it is low, all three are 0 and `rs_paddr` is 0.
- R7: A refill written in the same cycle as a lookup is not seen by that lookup. It is seen from the next cycle on.
- R8: A refill whose page number is already cached overwrites that slot. Otherwise it fills the lowest-numbered empty slot. When all slots are full it replaces a round-robin victim, starting at slot 0 and advancing by one per eviction.
- R9: `flush` empties every slot and returns the round-robin pointer to slot 0. A refill in the same cycle as a flush is dropped.
- R10: The first permitted access to a slot after it is loaded raises `fb_valid` together with the result. The first permitted write raises it again with `fb_dirty` = 1. Repeated accesses, and accesses that fault, raise nothing. `fb_vpn` carries the page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| lk_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| rs_valid | output | 1 | Lookup result present |
| rs_paddr | output | 32 | Physical address on a hit, else 0 |
| rs_hit | output | 1 | Permitted translation found |
| rs_miss | output | 1 | No translation cached; walk required |
| rs_fault | output | 1 | Translation found but access denied |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_ppn | input | 20 | Refill physical page number |
| rf_perm | input | 4 | Refill permissions {kernel-only, X, W, R} |
| flush | input | 1 | Invalidate all slots |
| fb_valid | output | 1 | Accessed/dirty state changed |
| fb_vpn | output | 20 | Page whose state changed |
| fb_dirty | output | 1 | Page is now dirty |

## Verification
The embedded assertions check, on every cycle, the properties that hold at every clock edge. Every result carries exactly one classification and there are no flags without a result. The offset passes through on hits, and the physical address is zeroed on misses and faults. Feedback appears only alongside a hit. No two slots ever match the same page. A flush leaves the cache empty. Other behaviour depends on history and only the bench's scenarios can show it: the one-cycle delay before a refill becomes visible, the invalid-first and round-robin victim order, the overwrite of a page that is already cached, flush beating refill, and the accessed and dirty reports happening only once. The bench's behavioural model tracks all of these and compares every output on every clock.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef struct packed {
      logic konly;
      logic ex;
      logic wr;
      logic rd;
   } perm_t;

   function automatic logic perm_denied(perm_t p, logic [1:0] acc, logic kernel);
      logic bad;
      case (acc)
         ACC_READ:  bad = !p.rd;
         ACC_WRITE: bad = !p.wr;
         ACC_EXEC:  bad = !p.ex;
         default:   bad = 1'b1;
      endcase
      return bad || (p.konly && !kernel);
   endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int N     = 16,
   parameter int VPN_W = 20,
   localparam int IDX_W = $clog2(N)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N-1:0]              valid_i,
   input  logic [N-1:0][VPN_W-1:0]   vpn_i,
   input  logic [VPN_W-1:0]          key_i,
   output logic                      hit_o,
   output logic [IDX_W-1:0]          idx_o
);
   logic [N-1:0] match;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = valid_i[g] && (vpn_i[g] == key_i);
   end

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) idx_o = IDX_W'(i);
      end
   end

   assign hit_o = |match;

   AST_NO_DUP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R8
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int N = 16,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     valid_i,
   input  logic             flush_i,
   input  logic             evict_i,
   output logic             full_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [IDX_W-1:0] rr_ptr;
   logic [IDX_W-1:0] free_idx;

   always_comb begin
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_i[i]) free_idx = IDX_W'(i);
      end
   end

   assign full_o = &valid_i;
   assign idx_o  = full_o ? rr_ptr : free_idx;

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         rr_ptr <= '0;
      end else if (evict_i) begin
         rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
      end
   end

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rr_ptr <= IDX_W'(N - 1)); // R8
   AST_EVICT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      evict_i |-> full_o); // R8
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
   parameter int N     = 16,
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   localparam int IDX_W = $clog2(N)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush_i,
   input  logic                        we_i,
   input  logic [IDX_W-1:0]            widx_i,
   input  logic [VPN_W-1:0]            wvpn_i,
   input  logic [PPN_W-1:0]            wppn_i,
   input  tlb_pkg::perm_t              wperm_i,
   input  logic                        ad_set_i,
   input  logic [IDX_W-1:0]            ad_idx_i,
   input  logic                        ad_dirty_i,
   output logic [N-1:0]                valid_o,
   output logic [N-1:0][VPN_W-1:0]     vpn_o,
   output logic [N-1:0][PPN_W-1:0]     ppn_o,
   output tlb_pkg::perm_t [N-1:0]      perm_o,
   output logic [N-1:0]                acc_o,
   output logic [N-1:0]                dirty_o
);
   for (genvar g = 0; g < N; g++) begin : g_slot
      logic wsel;
      logic asel;
      assign wsel = we_i && (widx_i == IDX_W'(g));
      assign asel = ad_set_i && (ad_idx_i == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n || flush_i) begin
            valid_o[g] <= 1'b0;
            acc_o[g]   <= 1'b0;
            dirty_o[g] <= 1'b0;
         end else if (wsel) begin
            valid_o[g] <= 1'b1;
            acc_o[g]   <= 1'b0;
            dirty_o[g] <= 1'b0;
         end else if (asel) begin
            acc_o[g]   <= 1'b1;
            dirty_o[g] <= dirty_o[g] | ad_dirty_i;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vpn_o[g]  <= '0;
            ppn_o[g]  <= '0;
            perm_o[g] <= '0;
         end else if (wsel && !flush_i) begin
            vpn_o[g]  <= wvpn_i;
            ppn_o[g]  <= wppn_i;
            perm_o[g] <= wperm_i;
         end
      end
   end

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush_i) |-> (valid_o == '0)); // R9
   AST_DIRTY_IMPLIES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      ((dirty_o & ~acc_o) == '0)); // R10
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb #(
   parameter int N_ENTRIES = 16,
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   localparam int VPN_W = VA_W - PAGE_BITS,
   localparam int PPN_W = PA_W - PAGE_BITS,
   localparam int IDX_W = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [1:0]        lk_acc,
   input  logic              lk_kernel,
   output logic              rs_valid,
   output logic [PA_W-1:0]   rs_paddr,
   output logic              rs_hit,
   output logic              rs_miss,
   output logic              rs_fault,
   input  logic              rf_valid,
   input  logic [VPN_W-1:0]  rf_vpn,
   input  logic [PPN_W-1:0]  rf_ppn,
   input  logic [3:0]        rf_perm,
   input  logic              flush,
   output logic              fb_valid,
   output logic [VPN_W-1:0]  fb_vpn,
   output logic              fb_dirty
);
   import tlb_pkg::*;

   if (N_ENTRIES < 2) begin : g_bad_depth
      $error("fa_tlb: N_ENTRIES must be at least 2");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("fa_tlb: PAGE_BITS must leave a page number in both addresses");
   end

   logic [N_ENTRIES-1:0]              s_valid;
   logic [N_ENTRIES-1:0][VPN_W-1:0]   s_vpn;
   logic [N_ENTRIES-1:0][PPN_W-1:0]   s_ppn;
   perm_t [N_ENTRIES-1:0]             s_perm;
   logic [N_ENTRIES-1:0]              s_acc;
   logic [N_ENTRIES-1:0]              s_dirty;

   logic [VPN_W-1:0]     lk_vpn;
   logic [PAGE_BITS-1:0] lk_off;
   logic                 lk_match;
   logic [IDX_W-1:0]     lk_idx;
   logic                 rf_match;
   logic [IDX_W-1:0]     rf_idx;
   logic                 vict_full;
   logic [IDX_W-1:0]     vict_idx;

   assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
   assign lk_off = lk_vaddr[PAGE_BITS-1:0];

   tlb_match #(.N(N_ENTRIES), .VPN_W(VPN_W)) u_lk_match (
      .clk(clk), .rst_n(rst_n), .valid_i(s_valid), .vpn_i(s_vpn),
      .key_i(lk_vpn), .hit_o(lk_match), .idx_o(lk_idx));

   tlb_match #(.N(N_ENTRIES), .VPN_W(VPN_W)) u_rf_match (
      .clk(clk), .rst_n(rst_n), .valid_i(s_valid), .vpn_i(s_vpn),
      .key_i(rf_vpn), .hit_o(rf_match), .idx_o(rf_idx));

   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic             evict;

   assign wr_en  = rf_valid && !flush;
   assign wr_idx = rf_match ? rf_idx : vict_idx;
   assign evict  = wr_en && !rf_match && vict_full;

   tlb_victim #(.N(N_ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .valid_i(s_valid), .flush_i(flush),
      .evict_i(evict), .full_o(vict_full), .idx_o(vict_idx));

   perm_t            sel_perm;
   logic             denied;
   logic             ok_hit;
   logic             is_write;
   logic             need_fb;
   logic             ad_set;

   assign sel_perm = s_perm[lk_idx];
   assign denied   = perm_denied(sel_perm, lk_acc, lk_kernel);
   assign ok_hit   = lk_valid && lk_match && !denied;
   assign is_write = (lk_acc == ACC_WRITE);
   assign need_fb  = !s_acc[lk_idx] || (is_write && !s_dirty[lk_idx]);
   assign ad_set   = ok_hit && need_fb;

   tlb_store #(.N(N_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .we_i(wr_en), .widx_i(wr_idx), .wvpn_i(rf_vpn), .wppn_i(rf_ppn),
      .wperm_i(perm_t'(rf_perm)),
      .ad_set_i(ad_set && !(wr_en && wr_idx == lk_idx)),
      .ad_idx_i(lk_idx), .ad_dirty_i(is_write),
      .valid_o(s_valid), .vpn_o(s_vpn), .ppn_o(s_ppn), .perm_o(s_perm),
      .acc_o(s_acc), .dirty_o(s_dirty));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_miss  <= 1'b0;
         rs_fault <= 1'b0;
         rs_paddr <= '0;
         fb_valid <= 1'b0;
         fb_vpn   <= '0;
         fb_dirty <= 1'b0;
      end else begin
         rs_valid <= lk_valid;
         rs_hit   <= ok_hit;
         rs_miss  <= lk_valid && !lk_match;
         rs_fault <= lk_valid && lk_match && denied;
         rs_paddr <= ok_hit ? {s_ppn[lk_idx], lk_off} : '0;
         fb_valid <= ad_set;
         fb_vpn   <= ad_set ? lk_vpn : '0;
         fb_dirty <= ad_set && (is_write || s_dirty[lk_idx]);
      end
   end

   AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid |-> ($countones({rs_hit, rs_miss, rs_fault}) == 1)); // R6
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_valid |-> (!rs_hit && !rs_miss && !rs_fault && rs_paddr == '0)); // R6
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      rs_hit |-> (rs_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0]))); // R2
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rs_miss |-> (rs_paddr == '0)); // R3
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rs_fault |-> (rs_paddr == '0)); // R4
   AST_FB_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      fb_valid |-> rs_hit); // R10
endmodule

// File: tb/fa_tlb_bench.sv
module fa_tlb_bench;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic [1:0]  lk_acc = '0;
   logic        lk_kernel = 1'b0;
   logic        rf_valid = 1'b0;
   logic [19:0] rf_vpn = '0;
   logic [19:0] rf_ppn = '0;
   logic [3:0]  rf_perm = '0;
   logic        flush = 1'b0;
   logic        rs_valid, rs_hit, rs_miss, rs_fault, fb_valid, fb_dirty;
   logic [31:0] rs_paddr;
   logic [19:0] fb_vpn;

   always #10 clk = ~clk;

   fa_tlb u_fa_tlb (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .lk_acc(lk_acc), .lk_kernel(lk_kernel), .rs_valid(rs_valid),
      .rs_paddr(rs_paddr), .rs_hit(rs_hit), .rs_miss(rs_miss),
      .rs_fault(rs_fault), .rf_valid(rf_valid), .rf_vpn(rf_vpn),
      .rf_ppn(rf_ppn), .rf_perm(rf_perm), .flush(flush),
      .fb_valid(fb_valid), .fb_vpn(fb_vpn), .fb_dirty(fb_dirty));

   int n_run = 0;
   int n_fail = 0;

   // behavioural model state
   bit       m_v[N];
   int       m_vpn[N];
   int       m_ppn[N];
   int       m_perm[N];
   bit       m_a[N];
   bit       m_d[N];
   int       m_ptr = 0;

   // expected outputs
   bit e_valid, e_hit, e_miss, e_fault, e_fb, e_fbd;
   int e_paddr, e_fbvpn;

   function automatic int find(int vpn);
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
      return -1;
   endfunction

   function automatic bit deny(int p, int acc, bit kern);
      bit b;
      case (acc)
         0: b = !p[0];
         1: b = !p[1];
         2: b = !p[2];
         default: b = 1;
      endcase
      return b || (p[3] && !kern);
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag);
      int li, wi, ad_i;
      bit ad, wr;
      int lvpn;
      lvpn = int'(lk_vaddr[31:12]);
      li = find(lvpn);
      e_valid = lk_valid; e_hit = 0; e_miss = 0; e_fault = 0;
      e_paddr = 0; e_fb = 0; e_fbd = 0; e_fbvpn = 0; ad = 0; ad_i = -1;
      wr = (lk_acc == 2'd1);
      if (lk_valid) begin
         if (li < 0) e_miss = 1;
         else if (deny(m_perm[li], int'(lk_acc), lk_kernel)) e_fault = 1;
         else begin
            e_hit = 1;
            e_paddr = (m_ppn[li] << 12) | int'(lk_vaddr[11:0]);
            if (!m_a[li] || (wr && !m_d[li])) begin
               ad = 1; ad_i = li;
               e_fb = 1; e_fbvpn = lvpn; e_fbd = wr || m_d[li];
            end
         end
      end
      // state update for this edge
      wi = -1;
      if (flush) begin
         for (int i = 0; i < N; i++) begin m_v[i] = 0; m_a[i] = 0; m_d[i] = 0; end
         m_ptr = 0;
      end else begin
         if (rf_valid) begin
            wi = find(int'(rf_vpn));
            if (wi < 0) begin
               for (int i = N - 1; i >= 0; i--) if (!m_v[i]) wi = i;
               if (wi < 0) begin wi = m_ptr; m_ptr = (m_ptr + 1) % N; end
            end
         end
         if (ad && ad_i != wi) begin
            m_a[ad_i] = 1;
            m_d[ad_i] = m_d[ad_i] | wr;
         end
         if (wi >= 0) begin
            m_v[wi] = 1; m_vpn[wi] = int'(rf_vpn); m_ppn[wi] = int'(rf_ppn);
            m_perm[wi] = int'(rf_perm); m_a[wi] = 0; m_d[wi] = 0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, "rs_valid", int'(rs_valid), int'(e_valid));
      check(tag, "rs_hit", int'(rs_hit), int'(e_hit));
      check(tag, "rs_miss", int'(rs_miss), int'(e_miss));
      check(tag, "rs_fault", int'(rs_fault), int'(e_fault));
      check(tag, "rs_paddr", int'(rs_paddr), e_paddr);
      check(tag, "fb_valid", int'(fb_valid), int'(e_fb));
      check(tag, "fb_vpn", int'(fb_vpn), e_fbvpn);
      check(tag, "fb_dirty", int'(fb_dirty), int'(e_fbd));
      lk_valid = 0; rf_valid = 0; flush = 0;
   endtask

   task automatic look(int va, int acc, bit kern);
      lk_valid = 1; lk_vaddr = 32'(va); lk_acc = 2'(acc); lk_kernel = kern;
   endtask

   task automatic fill(int vpn, int ppn, int perm);
      rf_valid = 1; rf_vpn = 20'(vpn); rf_ppn = 20'(ppn); rf_perm = 4'(perm);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_v[i] = 0; m_a[i] = 0; m_d[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_perm[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: quiet after reset, first lookup misses
      step("R1 idle after reset");
      look(32'h1000_0abc, 0, 0); step("R1 R3 first lookup misses");
      // R7: refill and lookup in same cycle; lookup sees old contents
      fill(20'hC0002, 20'h00002, 4'b0001);
      look(32'hC000_2345, 0, 0); step("R7 same-cycle refill unseen");
      // R2 R10: now hits with offset passthrough and accessed report
      look(32'hC000_2345, 0, 0); step("R2 R10 hit with first-access report");
      look(32'hC000_2FF0, 0, 0); step("R10 repeat read no report");
      // R4: write/exec/reserved to read-only entry
      look(32'hC000_2000, 1, 1); step("R4 write to read-only faults");
      look(32'hC000_2000, 2, 0); step("R4 exec without X faults");
      look(32'hC000_2000, 3, 1); step("R4 reserved access faults");
      // R5: kernel-only entry
      fill(20'h80001, 20'h12345, 4'b1111); step("R5 load kernel-only");
      look(32'h8000_1010, 0, 0); step("R5 user on kernel-only faults");
      look(32'h8000_1010, 2, 1); step("R5 kernel exec hits");
      look(32'hC000_2004, 0, 1); step("R5 kernel uses user page");
      // R10: dirty report
      fill(20'h00400, 20'hABCDE, 4'b0011); step("R10 load RW page");
      look(32'h0040_0008, 1, 0); step("R10 first write reports dirty");
      look(32'h0040_000C, 1, 0); step("R10 second write silent");
      look(32'h0040_0010, 0, 0); step("R10 read after dirty silent");
      // R8: overwrite existing vpn, clears accessed
      fill(20'h00400, 20'h55555, 4'b0011); step("R8 overwrite same page");
      look(32'h0040_0123, 0, 0); step("R8 R10 overwritten page new ppn");
      // R8: fill to full, then round-robin
      for (int k = 0; k < 13; k++) begin
         fill(20'h10000 + k, 20'h20000 + k, 4'b0111); step("R8 fill free slots");
      end
      fill(20'h3AAAA, 20'h0AAAA, 4'b0001); step("R8 evict slot 0");
      look(32'hC000_2000, 0, 0); step("R8 victim slot 0 now misses");
      fill(20'h3BBBB, 20'h0BBBB, 4'b0001); step("R8 evict slot 1");
      look(32'h8000_1000, 0, 1); step("R8 victim slot 1 now misses");
      look(32'h3AAA_A777, 0, 0); step("R8 evicting refill hits");
      look(32'h1000_5000, 2, 0); step("R8 survivor hits");
      // R9: flush beats refill; everything misses
      flush = 1; fill(20'h3CCCC, 20'h0CCCC, 4'b0001);
      look(32'h1000_5000, 0, 0); step("R9 lookup during flush sees old");
      look(32'h1000_5000, 0, 0); step("R9 flushed page misses");
      look(32'h3CCC_C000, 0, 0); step("R9 dropped refill misses");
      // R9: pointer reset - refill lands in slot 0 lowest free
      fill(20'h44444, 20'h04444, 4'b0001); step("R9 refill after flush");
      look(32'h4444_4001, 0, 0); step("R9 R2 refill after flush hits");
      step("R6 idle quiet");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule